// File: doc/BRIEF.md
# Device Error Status Register

This block is the 16-bit device status register of a PCI Express-style root port, located at configuration byte offset 4Ah. The link and transaction layers raise single-cycle pulses on an error event vector. The block sorts each pulse into one of three severity classes: correctable, non-fatal or fatal. It records each class in a sticky status bit. An unsupported request also has its own sticky flag.

Software reads the register through a small configuration port. It clears a recorded status bit by writing 1 to it, with the low byte enable asserted. Two bits are read-only: an aux-power indication that is always 1, and a transactions-pending indication that is always 0. All other bits are reserved and read as zero.

Top module: `devstat_reg`

## Requirements
- R1: While reset is low and just after it, a read at offset 4Ah returns 16'h0010.
- R2: On every read at offset 4Ah, bits 15:6 read 0, bit 5 (pending) reads 0 and bit 4 (aux power) reads 1. Writes never change these bits.
- R3: Fatal events set status bit 2 on the next clock. The fatal events are err_evt indices 0 (data link protocol), 1 (link training), 2 (receive buffer overflow) and 3 (malformed TLP).
- R4: Non-fatal events set status bit 1 on the next clock. The non-fatal events are indices 4 (poisoned TLP), 5 (unexpected completion), 6 (unsupported request), 7 (completer abort) and 8 (completion timeout).
- R5: Correctable events set status bit 0 on the next clock. The correctable events are indices 9 (receiver/framing), 10 (TLP CRC), 11 (DLLP CRC), 12 (replay number rollover) and 13 (replay timer timeout).
- R6: Index 6 (unsupported request) sets status bit 3 in addition to bit 1.
- R7: A write at offset 4Ah with cfg_be[0]=1 clears each of bits 3:0 whose cfg_wdata bit is 1. Bits written with 0 are unchanged. When cfg_be[0]=0, the write has no effect.
- R8: When a set event and a clearing write hit the same bit in one cycle, the bit reads 1 afterwards.
- R9: Events of different classes arriving in the same cycle each set their own bit.
- R10: cfg_rdata is combinational and shows the value held before the current cycle's update. A read at any other address returns 0. A write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables (bit 0 = bits 7:0) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data |
| err_evt | input | 14 | Error event pulses, indices as in R3 to R6 |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a new event of the same class, while other bits are also being cleared. Random stimulus alone seldom lines these up. The bench therefore runs a directed phase that first sets all four bits, then pairs each single-bit clear with an event pulse for that bit. After that, a long random phase mixes event vectors, byte enables and off-target addresses. Every clock, a behavioural model is compared against the read port.

// File: rtl/devstat_reg.sv
module devstat_reg #(
  parameter int ADDR_W  = 8,
  parameter int REG_OFS = 'h4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [13:0]       err_evt
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic [3:0] stat;
  logic       hit;
  logic [3:0] clr;
  logic [3:0] set;
  logic       unused_bits;

  assign hit = (cfg_addr == OFS);
  assign clr = (cfg_wr && hit && cfg_be[0]) ? cfg_wdata[3:0] : 4'b0000;

  assign set[2] = |err_evt[3:0];
  assign set[1] = |err_evt[8:4];
  assign set[0] = |err_evt[13:9];
  assign set[3] = err_evt[6];

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= 4'b0000;
    else        stat <= (stat & ~clr) | set;
  end

  assign cfg_rdata   = hit ? {10'b0, 1'b0, 1'b1, stat} : 16'h0000;
  assign unused_bits = ^{cfg_wdata[15:4], cfg_be[1]};
endmodule

module devstat_reg_chk #(
  parameter int ADDR_W  = 8,
  parameter int REG_OFS = 'h4A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [1:0]        cfg_be,
  input logic [15:0]       cfg_wdata,
  input logic [15:0]       cfg_rdata,
  input logic [13:0]       err_evt,
  input logic [3:0]        stat
);
  logic on_reg;
  logic wr_clr;
  assign on_reg = (cfg_addr == ADDR_W'(REG_OFS));
  assign wr_clr = cfg_wr && on_reg && cfg_be[0];

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    on_reg |-> cfg_rdata[15:4] == 12'h001);
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !on_reg |-> cfg_rdata == 16'h0000);
  a_r3_fatal_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt[3:0]) |=> stat[2]);
  a_r4_nonfatal_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt[8:4]) |=> stat[1]);
  a_r5_corr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt[13:9]) |=> stat[0]);
  a_r6_ur_both: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[6] |=> (stat[3] && stat[1]));
  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt == 14'h0 && (!wr_clr || cfg_wdata[3:0] == 4'h0)) |=> $stable(stat));
  a_r7_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && cfg_wdata[0] && err_evt[13:9] == 5'h0) |=> !stat[0]);
endmodule

bind devstat_reg devstat_reg_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (.*);

// File: tb/devstat_reg_tb.sv
`timescale 1ns/1ps
module devstat_reg_tb;
  localparam int AW = 8;
  localparam logic [AW-1:0] OFS = 8'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_addr = OFS;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_be = 2'b00;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic [13:0] err_evt = 14'h0;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";
  logic [3:0] m = 4'h0;
  bit done = 1'b0;

  devstat_reg #(.ADDR_W(AW), .REG_OFS('h4A)) u_dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    logic [3:0] s, c;
    s = 4'h0;
    for (int i = 0; i < 14; i++) if (err_evt[i]) begin
      if (i <= 3) s[2] = 1'b1;
      else if (i <= 8) s[1] = 1'b1;
      else s[0] = 1'b1;
      if (i == 6) s[3] = 1'b1;
    end
    c = (cfg_wr && cfg_addr == OFS && cfg_be[0]) ? cfg_wdata[3:0] : 4'h0;
    if (!rst_n) m <= 4'h0;
    else m <= (m & ~c) | s;
  end

  always @(negedge clk) if (!done) begin
    logic [15:0] exp;
    exp = (cfg_addr == OFS) ? {12'h001, m} : 16'h0;
    n_cmp++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h", tag, cfg_rdata, exp);
    end
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic w, input logic [1:0] be,
                       input logic [15:0] wd, input logic [13:0] ev);
    @(negedge clk); #2;
    cfg_addr = a; cfg_wr = w; cfg_be = be; cfg_wdata = wd; err_evt = ev;
  endtask

  task automatic idle(); drive(OFS, 1'b0, 2'b00, 16'h0, 14'h0); endtask

  initial begin
    tag = "R1 reset";
    repeat (3) idle();
    rst_n = 1'b1;
    idle(); idle();
    tag = "R3 fatal";
    for (int i = 0; i < 4; i++) begin
      drive(OFS, 1'b0, 2'b00, 16'h0, 14'(1) << i); idle();
      drive(OFS, 1'b1, 2'b01, 16'h000F, 14'h0); idle();
    end
    tag = "R4 nonfatal";
    for (int i = 4; i < 9; i++) begin
      drive(OFS, 1'b0, 2'b00, 16'h0, 14'(1) << i); idle();
      drive(OFS, 1'b1, 2'b01, 16'h000F, 14'h0); idle();
    end
    tag = "R5 correctable";
    for (int i = 9; i < 14; i++) begin
      drive(OFS, 1'b0, 2'b00, 16'h0, 14'(1) << i); idle();
      drive(OFS, 1'b1, 2'b01, 16'h000F, 14'h0); idle();
    end
    tag = "R6 unsupported";
    drive(OFS, 1'b0, 2'b00, 16'h0, 14'h0040); idle();
    tag = "R2 fixed bits";
    drive(OFS, 1'b1, 2'b11, 16'hFFC0, 14'h0); idle();
    drive(OFS, 1'b1, 2'b11, 16'h0000, 14'h0); idle();
    tag = "R7 byte enable";
    drive(OFS, 1'b1, 2'b10, 16'h000F, 14'h0); idle();
    drive(OFS, 1'b1, 2'b01, 16'h0008, 14'h0); idle();
    drive(OFS, 1'b1, 2'b01, 16'h0002, 14'h0); idle();
    tag = "R9 multiclass";
    drive(OFS, 1'b0, 2'b00, 16'h0, 14'h2211); idle();
    drive(OFS, 1'b0, 2'b00, 16'h0, 14'h0040); idle();
    tag = "R8 set beats clear";
    drive(OFS, 1'b1, 2'b01, 16'h0004, 14'h0001); idle();
    drive(OFS, 1'b1, 2'b01, 16'h0001, 14'h0200); idle();
    drive(OFS, 1'b1, 2'b01, 16'h000A, 14'h0040); idle();
    drive(OFS, 1'b1, 2'b01, 16'h000F, 14'h0010); idle();
    tag = "R10 other address";
    drive(8'h48, 1'b1, 2'b11, 16'hFFFF, 14'h0); idle();
    drive(8'h4C, 1'b0, 2'b00, 16'h0, 14'h0); idle();
    tag = "R10 random";
    for (int k = 0; k < 3000; k++) begin
      logic [13:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'h0;
      drive(($urandom_range(0, 7) == 0) ? 8'($urandom) : OFS, 1'($urandom), 2'($urandom),
            16'($urandom), ev);
    end
    idle(); idle();
    finish_run();
  end
endmodule